// File: doc/BRIEF.md
# Dynamic Voltage Reference Stepper

This block turns a 5-bit voltage-identification code into a digital reference value in millivolts. It does not follow the code directly. It looks at the code only on the clock edge where a one-cycle switching-cycle start strobe is high. A code that differs from the one in force must read the same on two strobes in a row before the block takes it. After that, the reference moves toward the new target in steps of 25 mV. It takes one step every second switching cycle and stops when it equals the target.

The first valid code seen after reset loads straight into the reference, with no stepping. After that, a newly taken code may replace the target while a move is still under way. The move then carries on from the present reference value. The all-ones code means output off. When that code is taken, the target and the reference stay as they are. The code-to-millivolt mapping is a single function in the package. A different voltage table can replace it there.

All pins are plain levels or strobes. The code is a level bus that the block samples, so there is no handshake on it and no back-pressure. The reference output is a registered level that holds its value between updates.

Top module: `dvid_ref_stepper`

## Requirements
- R1: While reset is asserted and after it is released, until the first strobe that carries a valid code, `vref_mv` is 0 and `busy` is 0.
- R2: The first strobe after reset with a valid code sets `vref_mv` directly to that code's voltage on the same edge, and `busy` stays 0.
- R3: `vid_code` is sampled only on edges where `cyc_start` is 1. A value that appears and goes away between two strobes has no effect, and `vref_mv` changes only on the edge after a strobe.
- R4: A code that differs from the code in force is taken only if it reads the same on the next strobe. A code present on a single strobe is dropped.
- R5: The strobe that takes a code restarts the step pacing. The first step lands on the second strobe after that one, and later steps come every second strobe.
- R6: Each step moves `vref_mv` by 25 mV toward the target, upward or downward, clamped at the target. When `vref_mv` equals the target, it holds.
- R7: `busy` is 1 from the strobe that takes a code whose voltage differs from `vref_mv` until `vref_mv` equals the target. It rises only on a strobe edge.
- R8: A code taken during a move replaces the target, and the move carries on from the present `vref_mv` without a jump.
- R9: Code 31 (all ones, output off) is taken like any other code, but it leaves the target and `vref_mv` unchanged.
- R10: Codes 0 to 30 select 1850 − 25·code millivolts. For example, code 10 gives 1600 mV, code 14 gives 1500 mV and code 2 gives 1800 mV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| vid_code | input | 5 | Voltage-identification code |
| vref_mv | output | 12 | Reference value in millivolts |
| busy | output | 1 | Reference is moving toward its target |

## Verification
The stepping function is driven with several code patterns:
- a falling move (1600 to 1500 mV) and a rising move (1500 to 1800 mV), which exercise both step directions and the clamp at the target;
- a code that appears only between strobes, which separates strobe-only sampling from level sampling;
- a code held for just one strobe, which separates the two-strobe qualification from one-strobe acceptance;
- a retarget in the middle of a move, which shows whether the move continues from the present value or restarts;
- the off code and a long run of random codes held for random numbers of strobes, compared on every clock against a behavioural model, which catch pacing phase errors and off-by-one errors in the step count.

// File: rtl/dvid_pkg.sv
package dvid_pkg;
  localparam int VID_W  = 5;
  localparam int MV_W   = 12;
  localparam int STEP_MV = 25;
  localparam int PACE   = 2;

  typedef struct packed {
    logic            ok;
    logic [MV_W-1:0] mv;
  } vid_entry_t;

  // Code-to-voltage table; replace this function to change the table.
  function automatic vid_entry_t vid_to_mv(logic [VID_W-1:0] code);
    vid_entry_t e;
    if (code == {VID_W{1'b1}}) begin
      e.ok = 1'b0;
      e.mv = '0;
    end else begin
      e.ok = 1'b1;
      e.mv = MV_W'(1850) - MV_W'(25) * MV_W'(code);
    end
    return e;
  endfunction
endpackage

// File: rtl/dvid_code_qualifier.sv
module dvid_code_qualifier
  import dvid_pkg::*;
#(
  parameter int CODE_W = VID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic [CODE_W-1:0] vid_code,
  input  logic              code_ok,
  output logic              load_o,
  output logic              accept_o
);
  logic              init_q;
  logic              pend_q;
  logic [CODE_W-1:0] held_q;
  logic [CODE_W-1:0] cand_q;
  logic              differs;

  assign differs  = (vid_code != held_q);
  assign load_o   = cyc_start && !init_q && code_ok;
  assign accept_o = cyc_start && init_q && differs && pend_q && (vid_code == cand_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= 1'b0;
      pend_q <= 1'b0;
      held_q <= '0;
      cand_q <= '0;
    end else if (cyc_start) begin
      if (!init_q) begin
        if (load_o) begin
          init_q <= 1'b1;
          held_q <= vid_code;
        end
      end else if (!differs) begin
        pend_q <= 1'b0;
      end else if (accept_o) begin
        held_q <= vid_code;
        pend_q <= 1'b0;
      end else begin
        cand_q <= vid_code;
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dvid_pacer.sv
module dvid_pacer #(
  parameter int STROBES_PER_STEP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic moving,
  input  logic restart,
  output logic step_o
);
  localparam int CW = (STROBES_PER_STEP > 1) ? $clog2(STROBES_PER_STEP) : 1;
  localparam logic [CW-1:0] LAST = CW'(STROBES_PER_STEP - 1);

  logic [CW-1:0] cnt_q;

  assign step_o = cyc_start && moving && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (!moving) begin
      cnt_q <= '0;
    end else if (cyc_start) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/dvid_ref_reg.sv
module dvid_ref_reg #(
  parameter int W    = 12,
  parameter int STEP = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         retarget,
  input  logic [W-1:0] new_mv,
  input  logic         step,
  output logic [W-1:0] ref_o,
  output logic [W-1:0] tgt_o
);
  localparam logic [W-1:0] STEP_V = W'(STEP);

  logic [W-1:0] ref_q, tgt_q, next_ref;

  always_comb begin
    next_ref = ref_q;
    if (ref_q < tgt_q) begin
      next_ref = ((tgt_q - ref_q) > STEP_V) ? ref_q + STEP_V : tgt_q;
    end else if (ref_q > tgt_q) begin
      next_ref = ((ref_q - tgt_q) > STEP_V) ? ref_q - STEP_V : tgt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= '0;
      tgt_q <= '0;
    end else if (load) begin
      ref_q <= new_mv;
      tgt_q <= new_mv;
    end else begin
      if (step)     ref_q <= next_ref;
      if (retarget) tgt_q <= new_mv;
    end
  end

  assign ref_o = ref_q;
  assign tgt_o = tgt_q;
endmodule

// File: rtl/dvid_ref_stepper.sv
module dvid_ref_stepper
  import dvid_pkg::*;
#(
  parameter int MV_BITS  = MV_W,
  parameter int STEP     = STEP_MV,
  parameter int PACE_CYC = PACE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_start,
  input  logic [VID_W-1:0]   vid_code,
  output logic [MV_BITS-1:0] vref_mv,
  output logic               busy
);
  vid_entry_t         entry;
  logic               load, accept, retarget, step;
  logic [MV_BITS-1:0] ref_w, tgt_w;

  assign entry    = vid_to_mv(vid_code);
  assign retarget = accept && entry.ok;

  dvid_code_qualifier #(.CODE_W(VID_W)) qual_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .vid_code(vid_code),
    .code_ok(entry.ok), .load_o(load), .accept_o(accept)
  );

  dvid_pacer #(.STROBES_PER_STEP(PACE_CYC)) pace_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .moving(busy),
    .restart(retarget), .step_o(step)
  );

  dvid_ref_reg #(.W(MV_BITS), .STEP(STEP)) ref_i (
    .clk(clk), .rst_n(rst_n), .load(load), .retarget(retarget),
    .new_mv(MV_BITS'(entry.mv)), .step(step), .ref_o(ref_w), .tgt_o(tgt_w)
  );

  assign vref_mv = ref_w;
  assign busy    = (ref_w != tgt_w);
endmodule

// File: rtl/dvid_ref_stepper_chk.sv
module dvid_ref_stepper_chk #(
  parameter int MV_BITS = 12,
  parameter int STEP    = 25
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cyc_start,
  input logic [MV_BITS-1:0] vref_mv,
  input logic               busy
);
  assert_update_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> $stable(vref_mv));

  assert_step_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((int'($past(vref_mv)) - int'(vref_mv) <= STEP) &&
              (int'(vref_mv) - int'($past(vref_mv)) <= STEP)));

  assert_hold_when_settled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && vref_mv != '0) |=> $stable(vref_mv));

  assert_busy_rises_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cyc_start));

  assert_idle_before_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (vref_mv == '0) |-> !busy);
endmodule

bind dvid_ref_stepper dvid_ref_stepper_chk #(.MV_BITS(MV_BITS), .STEP(STEP)) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .vref_mv(vref_mv), .busy(busy)
);

// File: tb/dvid_ref_stepper_tb.sv
module dvid_ref_stepper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW_CLKS    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_start = 1'b0;
  logic [4:0]  vid_code = 5'd10;
  logic [11:0] vref_mv;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_ref = 0, m_tgt = 0, m_held = 0, m_cand = 0, m_pace = 0;
  bit m_init = 0, m_pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dvid_ref_stepper dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .vid_code(vid_code),
    .vref_mv(vref_mv), .busy(busy)
  );

  function automatic bit tb_ok(int c);
    return c != 31;
  endfunction
  function automatic int tb_mv(int c);
    return 1850 - 25 * c;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model, one strobe at a time
  task automatic model_strobe(int c);
    bit m_busy;
    if (!m_init) begin
      if (tb_ok(c)) begin
        m_ref = tb_mv(c); m_tgt = m_ref; m_held = c; m_init = 1;
      end
      return;
    end
    m_busy = (m_ref != m_tgt);
    if (m_busy) begin
      if (m_pace == 1) begin
        if (m_ref < m_tgt) m_ref = (m_tgt - m_ref > 25) ? m_ref + 25 : m_tgt;
        else               m_ref = (m_ref - m_tgt > 25) ? m_ref - 25 : m_tgt;
        m_pace = 0;
      end else m_pace++;
    end else m_pace = 0;
    if (c == m_held) m_pend = 0;
    else if (m_pend && c == m_cand) begin
      m_held = c; m_pend = 0;
      if (tb_ok(c)) begin m_tgt = tb_mv(c); m_pace = 0; end
    end else begin
      m_cand = c; m_pend = 1;
    end
  endtask

  task automatic clk_step();
    @(posedge clk);
    if (cyc_start) model_strobe(int'(vid_code));
    @(negedge clk);
    check("R5/R6 reference vs model", int'(vref_mv), m_ref);
    check("R7 busy vs model", int'(busy), int'(m_ref != m_tgt));
  endtask

  task automatic sw_cycle(int c);
    vid_code = 5'(c);
    cyc_start = 1'b1;
    clk_step();
    cyc_start = 1'b0;
    for (int i = 1; i < SW_CLKS; i++) clk_step();
  endtask

  task automatic hold(int c, int n);
    for (int i = 0; i < n; i++) sw_cycle(c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset vref", int'(vref_mv), 0);
    check("R1 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    clk_step();
    check("R1 idle before strobe", int'(vref_mv), 0);

    // R2: first strobe loads directly
    vid_code = 5'd10; cyc_start = 1'b1; clk_step(); cyc_start = 1'b0;
    check("R2 direct load", int'(vref_mv), 1600);
    check("R2 not busy", int'(busy), 0);
    for (int i = 1; i < SW_CLKS; i++) clk_step();
    hold(10, 2);

    // R3: code present only between strobes
    vid_code = 5'd10; cyc_start = 1'b1; clk_step(); cyc_start = 1'b0;
    vid_code = 5'd3; clk_step(); clk_step();
    vid_code = 5'd10; clk_step();
    hold(10, 3);
    check("R3 glitch ignored", int'(vref_mv), 1600);
    check("R3 glitch not busy", int'(busy), 0);

    // R4: one-strobe code dropped
    sw_cycle(12);
    hold(10, 4);
    check("R4 single-strobe code dropped", int'(vref_mv), 1600);
    check("R4 not busy", int'(busy), 0);

    // R5/R7/R10: falling move 1600 -> 1500
    sw_cycle(14);
    check("R4 pending not busy", int'(busy), 0);
    sw_cycle(14);
    check("R7 busy after accept", int'(busy), 1);
    check("R5 no step on accept", int'(vref_mv), 1600);
    sw_cycle(14);
    check("R5 no step one strobe later", int'(vref_mv), 1600);
    sw_cycle(14);
    check("R5 first step on second strobe", int'(vref_mv), 1575);
    hold(14, 6);
    check("R10 code 14 voltage", int'(vref_mv), 1500);
    check("R7 busy cleared at target", int'(busy), 0);
    hold(14, 2);
    check("R6 holds at target", int'(vref_mv), 1500);

    // R6: rising move 1500 -> 1800
    hold(2, 30);
    check("R6 rising move done", int'(vref_mv), 1800);

    // R8: retarget mid-move
    hold(20, 6);
    check("R8 mid-move value", int'(vref_mv), 1750);
    sw_cycle(16);
    sw_cycle(16);
    check("R8 continues without jump", int'(vref_mv), 1725);
    check("R8 still busy", int'(busy), 1);
    hold(16, 25);
    check("R8 new target reached", int'(vref_mv), 1450);

    // R9: off code
    hold(31, 6);
    check("R9 off code leaves vref", int'(vref_mv), 1450);
    check("R9 off code not busy", int'(busy), 0);

    // random codes and holds
    for (int k = 0; k < 120; k++) begin
      int c, n;
      c = int'($urandom_range(0, 31));
      n = int'($urandom_range(1, 5));
      hold(c, n);
    end
    hold(7, 40);
    check("R10 code 7 voltage", int'(vref_mv), 1675);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule